// File: doc/BRIEF.md
# Serial Flash Erase Command Engine

This block is the device-side command logic of a serial NOR flash that handles erasing. A host talks to it over a single-bit SPI slave link (mode 0, MSB first): it drops the select line, clocks in an opcode and, for region erases, a three-byte address, then raises select. The engine oversamples the link with its own system clock. It decodes the opcode and accepts the command only if select rose after a whole number of bytes and the byte count matches the opcode. It then applies the write-enable latch and the per-sector lock inputs.

An accepted erase is handed to the memory array through a request/done pair, together with the aligned base address of the region and a size code. The engine times every erase against a cycle limit set for that erase size. It keeps a status byte and a flag status byte that the host side of the chip can read. Two opcodes set and clear the write-enable latch, and a third clears the error flags.

Top module: `sfe_erase_engine`

## Requirements
- R1: An erase opcode (20h, 52h, D8h, C7h, 60h) is ignored when the write-enable latch (status bit 1) is 0: no array request, and both registers stay unchanged.
- R2: 20h and 52h erase the 4 KiB region that holds the address (size code 0), D8h erases the 64 KiB region (size code 1), and C7h or 60h erase the whole array (size code 2, base 0). The address is taken MSB first on rising serial clock edges, and `arr_addr_o` carries the region base, which is the address with its low offset bits zeroed.
- R3: A command runs only when select rises with the bit count at a byte boundary and the byte count exact: 4 bytes for 20h, 52h and D8h, and 1 byte for all other opcodes. Any other framing is dropped, and the latch and flag bits keep their values.
- R4: `sec_lock_i` carries one lock bit per 64 KiB sector, indexed by address bits 23:16. A 4 KiB or 64 KiB erase that targets a locked sector does not start. The latch stays 1, and flag bits 5 and 1 are set.
- R5: A whole-array erase is refused in the same way when any lock bit is 1.
- R6: While an erase runs, status bit 0 is 1, flag bit 7 is 0, and `arr_req_o` is high with the address and size code held steady. Once the erase is over, status bit 0 is 0 and flag bit 7 is 1.
- R7: An erase ends on the cycle after `arr_done_i` is seen. The write-enable latch is 0 after every erase, whether it succeeded or failed.
- R8: If `arr_done_i` does not arrive, the erase is abandoned after exactly the configured limit for its size, counted in cycles of status bit 0 being high. Flag bit 5 is set and the latch is cleared.
- R9: Opcode 06h sets the write-enable latch and 04h clears it.
- R10: Opcode 50h clears flag bits 5 and 1.
- R11: A command whose opcode byte arrives while an erase is running has no effect.
- R12: After reset the status byte reads 00h, the flag byte reads 80h, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sclk | input | 1 | Serial clock, data taken on rising edge |
| spi_mosi | input | 1 | Serial data from host |
| sec_lock_i | input | 2**(8*ADDR_BYTES-SEC_AW) | Per-sector lock bits |
| arr_done_i | input | 1 | Array signals the erase finished |
| arr_req_o | output | 1 | Erase request to the array |
| arr_kind_o | output | 2 | Erase size code: 0 = 4 KiB, 1 = 64 KiB, 2 = whole array |
| arr_addr_o | output | 8*ADDR_BYTES | Base address of the region being erased |
| sr_o | output | 8 | Status: bit 0 busy, bit 1 write-enable latch |
| fsr_o | output | 8 | Flags: bit 7 ready, bit 5 erase error, bit 1 protection error |

## Verification
The bench keeps the default three-byte address and 64 KiB lock granularity. It lowers the erase limits to 200, 400 and 600 cycles for the three sizes. With these limits, every timeout path, including the whole-array one, ends within a few hundred cycles, so the exact length of an abandoned erase can be measured. The 400-cycle window for a 64 KiB erase is also longer than one full serial byte, so a second command can be sent into a running erase.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_WREN = 3'd1,
    CMD_WRDI = 3'd2,
    CMD_CLRF = 3'd3,
    CMD_SUB  = 3'd4,
    CMD_SEC  = 3'd5,
    CMD_BULK = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    ERS_SUB  = 2'd0,
    ERS_SEC  = 2'd1,
    ERS_BULK = 2'd2
  } ers_e;

  function automatic cmd_e op_class(input logic [7:0] op);
    case (op)
      8'h06:        return CMD_WREN;
      8'h04:        return CMD_WRDI;
      8'h50:        return CMD_CLRF;
      8'h20, 8'h52: return CMD_SUB;
      8'hD8:        return CMD_SEC;
      8'hC7, 8'h60: return CMD_BULK;
      default:      return CMD_NONE;
    endcase
  endfunction

  // Total frame length in bytes an opcode must arrive with
  function automatic int op_len(input cmd_e c, input int addr_bytes);
    if (c == CMD_SUB || c == CMD_SEC) return 1 + addr_bytes;
    return 1;
  endfunction

endpackage

// File: rtl/sfe_spi_rx.sv
module sfe_spi_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_cs_n,
  input  logic       spi_sclk,
  input  logic       spi_mosi,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       start_o,
  output logic       end_o,
  output logic       end_aligned_o
);

  // per stage: {cs, sclk, mosi}
  logic [2:0] sync_q [SYNC_STAGES];
  logic       cs_q, sclk_q;
  logic [6:0] shift_q, shift_n;
  logic [2:0] bit_q, bit_n;

  logic cs_s, sclk_s, mosi_s, sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 3'b100;
    end else begin
      sync_q[0] <= {spi_cs_n, spi_sclk, spi_mosi};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign cs_s   = sync_q[SYNC_STAGES-1][2];
  assign sclk_s = sync_q[SYNC_STAGES-1][1];
  assign mosi_s = sync_q[SYNC_STAGES-1][0];

  assign sclk_rise     = sclk_s & ~sclk_q & ~cs_s;
  assign start_o       = cs_q & ~cs_s;
  assign end_o         = ~cs_q & cs_s;
  assign end_aligned_o = (bit_q == 3'd0);

  always_comb begin
    bit_n      = bit_q;
    shift_n    = shift_q;
    byte_vld_o = 1'b0;
    byte_o     = {shift_q, mosi_s};
    if (cs_s) begin
      bit_n = 3'd0;
    end else if (sclk_rise) begin
      bit_n      = bit_q + 3'd1;
      shift_n    = {shift_q[5:0], mosi_s};
      byte_vld_o = (bit_q == 3'd7);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      shift_q <= '0;
      bit_q   <= '0;
    end else begin
      cs_q    <= cs_s;
      sclk_q  <= sclk_s;
      shift_q <= shift_n;
      bit_q   <= bit_n;
    end
  end

endmodule

// File: rtl/sfe_cmd_decode.sv
module sfe_cmd_decode
  import sfe_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  localparam int ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              start_i,
  input  logic              end_i,
  input  logic              end_aligned_i,
  input  logic              busy_i,
  output logic              cmd_vld_o,
  output cmd_e              cmd_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int CNT_W = $clog2(ADDR_BYTES + 3);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [7:0]        op_q, op_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              elig_q, elig_n;
  logic              vld_q, vld_n;
  cmd_e              cmd_q, cmd_n, cls;

  assign cls = op_class(op_q);

  always_comb begin
    op_n   = op_q;
    addr_n = addr_q;
    cnt_n  = cnt_q;
    elig_n = elig_q;
    vld_n  = 1'b0;
    cmd_n  = cmd_q;
    if (start_i) begin
      cnt_n  = '0;
      elig_n = 1'b0;
    end else if (byte_vld_i) begin
      if (cnt_q == '0) begin
        op_n   = byte_i;
        elig_n = ~busy_i;
      end else if (int'(cnt_q) <= ADDR_BYTES) begin
        addr_n = {addr_q[ADDR_W-9:0], byte_i};
      end
      if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
    end
    if (end_i && end_aligned_i && elig_q && cls != CMD_NONE &&
        int'(cnt_q) == op_len(cls, ADDR_BYTES)) begin
      vld_n = 1'b1;
      cmd_n = cls;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      elig_q <= 1'b0;
      vld_q  <= 1'b0;
      cmd_q  <= CMD_NONE;
    end else begin
      op_q   <= op_n;
      addr_q <= addr_n;
      cnt_q  <= cnt_n;
      elig_q <= elig_n;
      vld_q  <= vld_n;
      cmd_q  <= cmd_n;
    end
  end

  assign cmd_vld_o = vld_q;
  assign cmd_o     = cmd_q;
  assign addr_o    = addr_q;

endmodule

// File: rtl/sfe_prot_check.sv
module sfe_prot_check
  import sfe_pkg::*;
#(
  parameter int IDX_W    = 8,
  localparam int NUM_SEC = 1 << IDX_W
) (
  input  cmd_e               cmd_i,
  input  logic [IDX_W-1:0]   sec_idx_i,
  input  logic [NUM_SEC-1:0] lock_i,
  output logic               blocked_o
);

  always_comb begin
    if (cmd_i == CMD_BULK) blocked_o = |lock_i;
    else                   blocked_o = lock_i[sec_idx_i];
  end

endmodule

// File: rtl/sfe_erase_ctrl.sv
module sfe_erase_ctrl
  import sfe_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SUB_AW   = 12,
  parameter int SEC_AW   = 16,
  parameter int SUB_CYC  = 1000000,
  parameter int SEC_CYC  = 8000000,
  parameter int BULK_CYC = 64000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld_i,
  input  cmd_e              cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              blocked_i,
  input  logic              arr_done_i,
  output logic              busy_o,
  output logic              arr_req_o,
  output logic [1:0]        arr_kind_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [7:0]        sr_o,
  output logic [7:0]        fsr_o
);

  localparam int MAX_CYC = (BULK_CYC > SEC_CYC) ?
                           ((BULK_CYC > SUB_CYC) ? BULK_CYC : SUB_CYC) :
                           ((SEC_CYC > SUB_CYC) ? SEC_CYC : SUB_CYC);
  localparam int TMR_W = $clog2(MAX_CYC + 1);
  localparam logic [ADDR_W-1:0] SUB_MASK = ~((ADDR_W'(1) << SUB_AW) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] SEC_MASK = ~((ADDR_W'(1) << SEC_AW) - ADDR_W'(1));

  typedef enum logic {ST_IDLE, ST_ERASE} st_e;

  st_e               st_q, st_n;
  logic              wel_q, wel_n;
  logic              erre_q, erre_n;
  logic              errp_q, errp_n;
  logic [TMR_W-1:0]  tmr_q, tmr_n, lim_q, lim_n;
  logic [ADDR_W-1:0] base_q, base_n;
  ers_e              kind_q, kind_n;
  logic              tmr_en;

  assign tmr_en = (st_q == ST_ERASE) || (st_n == ST_ERASE);

  always_comb begin
    st_n   = st_q;
    wel_n  = wel_q;
    erre_n = erre_q;
    errp_n = errp_q;
    tmr_n  = tmr_q;
    lim_n  = lim_q;
    base_n = base_q;
    kind_n = kind_q;
    unique case (st_q)
      ST_IDLE: begin
        tmr_n = '0;
        if (cmd_vld_i) begin
          case (cmd_i)
            CMD_WREN: wel_n = 1'b1;
            CMD_WRDI: wel_n = 1'b0;
            CMD_CLRF: begin
              erre_n = 1'b0;
              errp_n = 1'b0;
            end
            CMD_SUB, CMD_SEC, CMD_BULK: begin
              if (wel_q) begin
                if (blocked_i) begin
                  erre_n = 1'b1;
                  errp_n = 1'b1;
                end else begin
                  st_n = ST_ERASE;
                  if (cmd_i == CMD_SUB) begin
                    base_n = addr_i & SUB_MASK;
                    kind_n = ERS_SUB;
                    lim_n  = TMR_W'(SUB_CYC);
                  end else if (cmd_i == CMD_SEC) begin
                    base_n = addr_i & SEC_MASK;
                    kind_n = ERS_SEC;
                    lim_n  = TMR_W'(SEC_CYC);
                  end else begin
                    base_n = '0;
                    kind_n = ERS_BULK;
                    lim_n  = TMR_W'(BULK_CYC);
                  end
                end
              end
            end
            default: ;
          endcase
        end
      end
      ST_ERASE: begin
        if (arr_done_i) begin
          st_n  = ST_IDLE;
          wel_n = 1'b0;
        end else if (tmr_q == lim_q - 1'b1) begin
          st_n   = ST_IDLE;
          wel_n  = 1'b0;
          erre_n = 1'b1;
        end else begin
          tmr_n = tmr_q + 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wel_q  <= 1'b0;
      erre_q <= 1'b0;
      errp_q <= 1'b0;
      lim_q  <= '0;
      base_q <= '0;
      kind_q <= ERS_SUB;
    end else begin
      st_q   <= st_n;
      wel_q  <= wel_n;
      erre_q <= erre_n;
      errp_q <= errp_n;
      lim_q  <= lim_n;
      base_q <= base_n;
      kind_q <= kind_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_n;
  end

  assign busy_o     = (st_q == ST_ERASE);
  assign arr_req_o  = busy_o;
  assign arr_kind_o = kind_q;
  assign arr_addr_o = base_q;
  assign sr_o       = {6'b0, wel_q, busy_o};
  assign fsr_o      = {~busy_o, 1'b0, erre_q, 3'b0, errp_q, 1'b0};

endmodule

// File: rtl/sfe_erase_engine.sv
module sfe_erase_engine
  import sfe_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int SUB_AW     = 12,
  parameter int SEC_AW     = 16,
  parameter int SUB_CYC    = 1000000,
  parameter int SEC_CYC    = 8000000,
  parameter int BULK_CYC   = 64000000,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int IDX_W     = ADDR_W - SEC_AW,
  localparam int NUM_SEC   = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_cs_n,
  input  logic               spi_sclk,
  input  logic               spi_mosi,
  input  logic [NUM_SEC-1:0] sec_lock_i,
  input  logic               arr_done_i,
  output logic               arr_req_o,
  output logic [1:0]         arr_kind_o,
  output logic [ADDR_W-1:0]  arr_addr_o,
  output logic [7:0]         sr_o,
  output logic [7:0]         fsr_o
);

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic              byte_vld, start, fin, fin_aligned, busy, cmd_vld, blocked;
  logic [7:0]        byte_d;
  logic [ADDR_W-1:0] cmd_addr;
  cmd_e              cmd;

  sfe_spi_rx #(.SYNC_STAGES(2)) rx_i (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .spi_cs_n     (spi_cs_n),
    .spi_sclk     (spi_sclk),
    .spi_mosi     (spi_mosi),
    .byte_vld_o   (byte_vld),
    .byte_o       (byte_d),
    .start_o      (start),
    .end_o        (fin),
    .end_aligned_o(fin_aligned)
  );

  sfe_cmd_decode #(.ADDR_BYTES(ADDR_BYTES)) dec_i (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .byte_vld_i   (byte_vld),
    .byte_i       (byte_d),
    .start_i      (start),
    .end_i        (fin),
    .end_aligned_i(fin_aligned),
    .busy_i       (busy),
    .cmd_vld_o    (cmd_vld),
    .cmd_o        (cmd),
    .addr_o       (cmd_addr)
  );

  sfe_prot_check #(.IDX_W(IDX_W)) prot_i (
    .cmd_i    (cmd),
    .sec_idx_i(cmd_addr[ADDR_W-1:SEC_AW]),
    .lock_i   (sec_lock_i),
    .blocked_o(blocked)
  );

  sfe_erase_ctrl #(
    .ADDR_W  (ADDR_W),
    .SUB_AW  (SUB_AW),
    .SEC_AW  (SEC_AW),
    .SUB_CYC (SUB_CYC),
    .SEC_CYC (SEC_CYC),
    .BULK_CYC(BULK_CYC)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .cmd_vld_i (cmd_vld),
    .cmd_i     (cmd),
    .addr_i    (cmd_addr),
    .blocked_i (blocked),
    .arr_done_i(arr_done_i),
    .busy_o    (busy),
    .arr_req_o (arr_req_o),
    .arr_kind_o(arr_kind_o),
    .arr_addr_o(arr_addr_o),
    .sr_o      (sr_o),
    .fsr_o     (fsr_o)
  );

endmodule

// File: rtl/sfe_erase_chk.sv
module sfe_erase_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arr_done_i,
  input logic              arr_req_o,
  input logic [1:0]        arr_kind_o,
  input logic [ADDR_W-1:0] arr_addr_o,
  input logic [7:0]        sr_o,
  input logic [7:0]        fsr_o
);

  p_start_wel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_o[0]) |-> $past(sr_o[1]));

  p_prot_keeps_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsr_o[1]) |-> (sr_o[1] && fsr_o[5] && !sr_o[0]));

  p_target_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req_o && $past(arr_req_o)) |-> ($stable(arr_addr_o) && $stable(arr_kind_o)));

  p_wel_clear_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_o[0]) |-> !sr_o[1]);

  p_timeout_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sr_o[0]) && !$past(arr_done_i)) |-> fsr_o[5]);

  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_o[0] && $past(sr_o[0])) |-> ($stable(fsr_o[1]) && sr_o[1]));

endmodule

bind sfe_erase_engine sfe_erase_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .arr_done_i(arr_done_i),
  .arr_req_o (arr_req_o),
  .arr_kind_o(arr_kind_o),
  .arr_addr_o(arr_addr_o),
  .sr_o      (sr_o),
  .fsr_o     (fsr_o)
);

// File: tb/sfe_erase_engine_tb_top.sv
module sfe_erase_engine_tb_top;

  localparam int SUBC = 200;
  localparam int SECC = 400;
  localparam int BLKC = 600;
  localparam int HALF = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1;
  logic         sclk = 1'b0;
  logic         mosi = 1'b0;
  logic [255:0] lock = '0;
  logic         done = 1'b0;
  logic         req;
  logic [1:0]   kind;
  logic [23:0]  addr;
  logic [7:0]   sr, fsr;

  int n_chk = 0, n_ok = 0, dly = 0, acnt = 0, busy_cnt = 0;

  always #10 clk = ~clk;

  sfe_erase_engine #(
    .SUB_CYC(SUBC), .SEC_CYC(SECC), .BULK_CYC(BLKC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .sec_lock_i(lock), .arr_done_i(done), .arr_req_o(req), .arr_kind_o(kind),
    .arr_addr_o(addr), .sr_o(sr), .fsr_o(fsr)
  );

  // array model: done pulse after dly request cycles (dly 0 = never)
  initial forever begin
    @(negedge clk);
    if (req) begin
      acnt++;
      done = (dly != 0 && acnt == dly);
    end else begin
      acnt = 0;
      done = 1'b0;
    end
    if (sr[0]) busy_cnt++;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (ok) n_ok++;
    else $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
  endtask

  task automatic spi_send(input logic [7:0] op, input logic [23:0] adr,
                          input int nb, input int xb);
    logic [39:0] fr;
    fr = {op, adr, 8'h00};
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nb * 8 + xb; i++) begin
      mosi = fr[39-i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 3000 && sr[0]; k++) @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] adr;
    logic [2:0]  nb;
    logic [2:0]  xb;
    logic        lk;
    logic [9:0]  dl;
    logic        st;
    logic [23:0] ea;
    logic [1:0]  ek;
    logic [7:0]  esr;
    logic [7:0]  efsr;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{8'h20, 24'h012345, 3'd4, 3'd0, 1'b0, 10'd0,  1'b0, 24'h0,      2'd0, 8'h00, 8'h80}, // R1
    '{8'h06, 24'h0,      3'd1, 3'd0, 1'b0, 10'd0,  1'b0, 24'h0,      2'd0, 8'h02, 8'h80}, // R9
    '{8'h20, 24'h012345, 3'd4, 3'd0, 1'b0, 10'd30, 1'b1, 24'h012000, 2'd0, 8'h00, 8'h80}, // R2
    '{8'h06, 24'h0,      3'd1, 3'd0, 1'b0, 10'd0,  1'b0, 24'h0,      2'd0, 8'h02, 8'h80},
    '{8'hD8, 24'h0ABCDE, 3'd4, 3'd0, 1'b0, 10'd50, 1'b1, 24'h0A0000, 2'd1, 8'h00, 8'h80}, // R2
    '{8'h06, 24'h0,      3'd1, 3'd0, 1'b0, 10'd0,  1'b0, 24'h0,      2'd0, 8'h02, 8'h80},
    '{8'h52, 24'h0456FF, 3'd4, 3'd3, 1'b0, 10'd0,  1'b0, 24'h0,      2'd0, 8'h02, 8'h80}, // R3
    '{8'h52, 24'h034000, 3'd4, 3'd0, 1'b1, 10'd0,  1'b0, 24'h0,      2'd0, 8'h02, 8'hA2}, // R4
    '{8'h50, 24'h0,      3'd1, 3'd0, 1'b0, 10'd0,  1'b0, 24'h0,      2'd0, 8'h02, 8'h80}, // R10
    '{8'hC7, 24'h0,      3'd1, 3'd0, 1'b1, 10'd0,  1'b0, 24'h0,      2'd0, 8'h02, 8'hA2}, // R5
    '{8'h50, 24'h0,      3'd1, 3'd0, 1'b0, 10'd0,  1'b0, 24'h0,      2'd0, 8'h02, 8'h80}, // R10
    '{8'h60, 24'h0,      3'd1, 3'd0, 1'b0, 10'd0,  1'b1, 24'h0,      2'd2, 8'h00, 8'hA0}, // R8
    '{8'h50, 24'h0,      3'd1, 3'd0, 1'b0, 10'd0,  1'b0, 24'h0,      2'd0, 8'h00, 8'h80}, // R10
    '{8'h06, 24'h0,      3'd1, 3'd0, 1'b0, 10'd0,  1'b0, 24'h0,      2'd0, 8'h02, 8'h80}, // R9
    '{8'h04, 24'h0,      3'd1, 3'd0, 1'b0, 10'd0,  1'b0, 24'h0,      2'd0, 8'h00, 8'h80}, // R9
    '{8'h06, 24'h0,      3'd1, 3'd0, 1'b0, 10'd0,  1'b0, 24'h0,      2'd0, 8'h02, 8'h80},
    '{8'h20, 24'h012345, 3'd3, 3'd0, 1'b0, 10'd0,  1'b0, 24'h0,      2'd0, 8'h02, 8'h80}, // R3
    '{8'h52, 24'h0FFFFF, 3'd4, 3'd0, 1'b0, 10'd20, 1'b1, 24'h0FF000, 2'd0, 8'h00, 8'h80}, // R2
    '{8'h06, 24'h0,      3'd1, 3'd0, 1'b0, 10'd0,  1'b0, 24'h0,      2'd0, 8'h02, 8'h80},
    '{8'hD8, 24'h031000, 3'd4, 3'd0, 1'b1, 10'd0,  1'b0, 24'h0,      2'd0, 8'h02, 8'hA2}, // R4
    '{8'h50, 24'h0,      3'd1, 3'd0, 1'b0, 10'd0,  1'b0, 24'h0,      2'd0, 8'h02, 8'h80},
    '{8'hC7, 24'h0,      3'd1, 3'd0, 1'b0, 10'd40, 1'b1, 24'h0,      2'd2, 8'h00, 8'h80}, // R2
    '{8'h06, 24'h0,      3'd1, 3'd0, 1'b0, 10'd0,  1'b0, 24'h0,      2'd0, 8'h02, 8'h80},
    '{8'hC7, 24'h0,      3'd1, 3'd2, 1'b0, 10'd0,  1'b0, 24'h0,      2'd0, 8'h02, 8'h80}  // R3
  };

  function automatic int lim_of(input logic [1:0] k);
    if (k == 2'd0) return SUBC;
    if (k == 2'd1) return SECC;
    return BLKC;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_ok, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R12: reset values
    chk(sr == 8'h00, "R12", "status after reset", sr, 8'h00);
    chk(fsr == 8'h80, "R12", "flags after reset", fsr, 8'h80);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(req == 1'b0, "R12", "request after reset", req, 0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VECS[v];
      dly = int'(t.dl);
      lock = t.lk ? (256'h1 << 3) : '0;
      busy_cnt = 0;
      spi_send(t.op, t.adr, int'(t.nb), int'(t.xb));
      if (t.st) begin
        chk(req && sr[0] && !fsr[7], "R6", $sformatf("vec %0d running", v),
            {req, sr[0], fsr[7]}, 3'b110);
        chk(addr == t.ea, "R2", $sformatf("vec %0d base", v), addr, t.ea);
        chk(kind == t.ek, "R2", $sformatf("vec %0d size", v), kind, t.ek);
      end else begin
        chk(!req, "R3", $sformatf("vec %0d no request", v), req, 0);
      end
      wait_idle();
      chk(sr == t.esr, "R7", $sformatf("vec %0d status", v), sr, t.esr);
      chk(fsr == t.efsr, "R10", $sformatf("vec %0d flags", v), fsr, t.efsr);
      if (t.st) begin
        int ex;
        ex = (t.dl != 0) ? int'(t.dl) : lim_of(t.ek);
        chk(busy_cnt == ex, "R8", $sformatf("vec %0d busy cycles", v), busy_cnt, ex);
      end
    end
    lock = '0;

    // R11: write-enable sent during a running erase has no effect; R8 sector limit
    spi_send(8'h06, 24'h0, 1, 0);
    dly = 0;
    busy_cnt = 0;
    spi_send(8'hD8, 24'h050000, 4, 0);
    spi_send(8'h06, 24'h0, 1, 0);
    chk(sr == 8'h03 && fsr == 8'h00, "R6", "mid-erase registers", {sr, fsr}, 16'h0300);
    wait_idle();
    chk(sr == 8'h00, "R11", "latch after ignored enable", sr, 8'h00);
    chk(fsr == 8'hA0, "R8", "flags after sector timeout", fsr, 8'hA0);
    chk(busy_cnt == SECC, "R8", "sector timeout cycles", busy_cnt, SECC);

    // R12: reset in the middle of a session
    spi_send(8'h50, 24'h0, 1, 0);
    spi_send(8'h06, 24'h0, 1, 0);
    chk(sr == 8'h02, "R9", "latch set before reset", sr, 8'h02);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sr == 8'h00 && fsr == 8'h80, "R12", "registers in reset", {sr, fsr}, 16'h0080);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule